// File: doc/BRIEF.md
# Pipelined Ones-Count Flash Decoder

This block turns the raw decision vector of a flash comparator array into a binary code. The code is the number of comparators that tripped. The comparators may carry offsets of several LSBs, so their outputs rarely form a clean thermometer pattern. The decoder does not try to find a transition edge and has no bubble-suppression logic. It counts asserted bits, and that count does not depend on where the bits sit.

The count comes from a carry-save tree of full adders. Each adder takes three bits of one weight and returns a sum bit of that weight and a carry bit of the next weight. A half adder is used only where a column holds exactly two bits. The adder levels are split evenly across a fixed number of register stages, which bounds the logic depth between registers.

Input and output are valid/ready streams, and the whole pipeline advances as one unit:
- `in_ready` equals `!out_valid || out_ready`, so it depends combinationally on `out_ready`.
- While `out_valid` is high and `out_ready` is low, every stage holds its contents and `out_count` stays stable.

A second, slower readout port taps the output stream. It reports the first accepted result and then every 32nd one after it. This port has no ready signal.

Top module: `popc_decoder`

## Requirements
- R1: When `out_valid` is high, `out_count` equals the number of ones in the corresponding accepted `in_bits` word, whatever the positions of those ones (bubbled or scattered patterns included).
- R2: An all-zero input word yields 0 and an all-ones input word yields 63.
- R3: With `out_ready` held high, an input word accepted in cycle n appears on the output in cycle n+3. Words accepted in consecutive cycles leave in consecutive cycles.
- R4: `out_valid` is never high unless an accepted input word is still owed to the output. A cycle without `in_valid` produces no result.
- R5: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_count` hold their values.
- R6: Results leave in the order their inputs were accepted, with none lost or duplicated under any pattern of stalls and gaps.
- R7: During and just after reset, `out_valid`, `dec_valid` and `out_count` are low, and the readout counter starts at zero.
- R8: Output transfers (`out_valid && out_ready`) are numbered 0, 1, 2, … from reset. For every transfer whose number is a multiple of 32, `dec_valid` pulses high for one cycle in the following cycle, and `dec_count` carries that transfer's count. No other cycle raises `dec_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Pipeline can accept a word this cycle |
| in_bits | input | 63 | Comparator decisions, any order |
| out_valid | output | 1 | Count present |
| out_ready | input | 1 | Consumer takes the count this cycle |
| out_count | output | 6 | Number of ones in the word |
| dec_valid | output | 1 | One-cycle pulse for a decimated result |
| dec_count | output | 6 | Decimated count |

## Verification
The bench instantiates the default parameters: 63 inputs, a 6-bit count, three register stages and a readout ratio of 32. With 63 inputs the all-ones word drives every column of the tree, including the top one whose carries must vanish. The default tree has ten adder levels, split four, four and two across the stages. Roughly a thousand output transfers under random stalls wrap the readout counter many times, so its wrap and its dependence on transfers rather than cycles are both exercised.

// File: rtl/popc_pkg.sv
package popc_pkg;

  localparam int MAXC = 32;

  // Column heights of the carry-save tree after `lvl` reduction levels.
  function automatic int col_height(input int n_in, input int n_cols,
                                    input int lvl, input int col);
    int h  [MAXC];
    int nh [MAXC];
    for (int c = 0; c < MAXC; c++) h[c] = 0;
    h[0] = n_in;
    for (int l = 0; l < lvl; l++) begin
      for (int c = 0; c < MAXC; c++) nh[c] = 0;
      for (int c = 0; c < n_cols; c++) begin
        if (h[c] == 2) begin
          nh[c] += 1;
          if (c + 1 < n_cols) nh[c+1] += 1;
        end else begin
          nh[c] += h[c] / 3 + h[c] % 3;
          if (c + 1 < n_cols) nh[c+1] += h[c] / 3;
        end
      end
      for (int c = 0; c < MAXC; c++) h[c] = nh[c];
    end
    return h[col];
  endfunction

  // Number of levels until every column holds at most one bit.
  function automatic int level_count(input int n_in, input int n_cols);
    int lv;
    bit busy;
    lv   = 0;
    busy = 1'b1;
    for (int l = 0; l < 64; l++) begin
      if (busy) begin
        busy = 1'b0;
        for (int c = 0; c < n_cols; c++)
          if (col_height(n_in, n_cols, l, c) > 1) busy = 1'b1;
        if (busy) lv = l + 1;
      end
    end
    return lv;
  endfunction

  // Three bits of equal weight -> {carry, sum}.
  function automatic logic [1:0] fa3(input logic a, input logic b, input logic c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

endpackage

// File: rtl/popc_level.sv
module popc_level #(
  parameter int N_IN  = 63,
  parameter int W_OUT = 6,
  parameter int LVL   = 0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [W_OUT-1:0][N_IN-1:0]   i_bits,
  output logic [W_OUT-1:0][N_IN-1:0]   o_bits
);
  import popc_pkg::*;

  localparam int CIW = (W_OUT > 1) ? $clog2(W_OUT) : 1;
  localparam int KIW = (N_IN  > 1) ? $clog2(N_IN)  : 1;

  logic pad;   // any bit outside the live column heights, or a lost top carry

  always_comb begin
    int fill [W_OUT];
    int h;
    logic [1:0] r;
    o_bits = '0;
    pad    = 1'b0;
    r      = '0;
    for (int c = 0; c < W_OUT; c++) fill[c] = 0;
    for (int c = 0; c < W_OUT; c++) begin
      h = col_height(N_IN, W_OUT, LVL, c);
      for (int k = 0; k < N_IN; k++)
        if (k >= h) pad = pad | i_bits[CIW'(c)][KIW'(k)];
      if (h == 2) begin
        r = {i_bits[CIW'(c)][0] & i_bits[CIW'(c)][1],
             i_bits[CIW'(c)][0] ^ i_bits[CIW'(c)][1]};
        o_bits[CIW'(c)][KIW'(fill[c])] = r[0];
        fill[c] = fill[c] + 1;
        if (c + 1 < W_OUT) begin
          o_bits[CIW'(c+1)][KIW'(fill[c+1])] = r[1];
          fill[c+1] = fill[c+1] + 1;
        end else begin
          pad = pad | r[1];
        end
      end else begin
        for (int f = 0; f < h / 3; f++) begin
          r = fa3(i_bits[CIW'(c)][KIW'(3*f)],
                  i_bits[CIW'(c)][KIW'(3*f+1)],
                  i_bits[CIW'(c)][KIW'(3*f+2)]);
          o_bits[CIW'(c)][KIW'(fill[c])] = r[0];
          fill[c] = fill[c] + 1;
          if (c + 1 < W_OUT) begin
            o_bits[CIW'(c+1)][KIW'(fill[c+1])] = r[1];
            fill[c+1] = fill[c+1] + 1;
          end else begin
            pad = pad | r[1];
          end
        end
        for (int p = 0; p < h % 3; p++) begin
          o_bits[CIW'(c)][KIW'(fill[c])] = i_bits[CIW'(c)][KIW'(3*(h/3)+p)];
          fill[c] = fill[c] + 1;
        end
      end
    end
  end

  // R1
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) pad == 1'b0)
    else $error("bit outside live tree columns or top carry set at level %0d", LVL);

endmodule

// File: rtl/popc_stage.sv
module popc_stage #(
  parameter int N_IN   = 63,
  parameter int W_OUT  = 6,
  parameter int LVL_LO = 0,
  parameter int LVL_HI = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  input  logic                        i_valid,
  input  logic [W_OUT-1:0][N_IN-1:0]  i_bits,
  output logic                        o_valid,
  output logic [W_OUT-1:0][N_IN-1:0]  o_bits
);
  localparam int NL = LVL_HI - LVL_LO;

  typedef logic [W_OUT-1:0][N_IN-1:0] cols_t;

  cols_t lnk [NL+1];

  assign lnk[0] = i_bits;

  for (genvar g = 0; g < NL; g++) begin : g_lvl
    popc_level #(.N_IN(N_IN), .W_OUT(W_OUT), .LVL(LVL_LO + g)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .i_bits (lnk[g]),
      .o_bits (lnk[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_bits  <= '0;
    end else if (adv) begin
      o_valid <= i_valid;
      if (i_valid) o_bits <= lnk[NL];
    end
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(o_valid) && $stable(o_bits))
    else $error("stage moved while stalled");

  // R4
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !i_valid |=> !o_valid)
    else $error("stage produced a result from an empty slot");

endmodule

// File: rtl/popc_decim.sv
module popc_decim #(
  parameter int W_OUT = 6,
  parameter int RATIO = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [W_OUT-1:0] i_count,
  output logic             o_valid,
  output logic [W_OUT-1:0] o_count
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  logic [CW-1:0] cnt;
  logic          pick;

  assign pick = fire && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      o_valid <= 1'b0;
      o_count <= '0;
    end else begin
      o_valid <= pick;
      if (pick) o_count <= i_count;
      if (fire) cnt <= (cnt == CW'(RATIO - 1)) ? '0 : cnt + 1'b1;
    end
  end

  // R8
  dec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(fire))
    else $error("readout pulse without an output transfer");

  if (RATIO > 1) begin : g_gap
    // R8
    dec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |=> !o_valid)
      else $error("readout pulses in adjacent cycles");
  end

endmodule

// File: rtl/popc_decoder.sv
module popc_decoder #(
  parameter int N_IN      = 63,
  parameter int W_OUT     = $clog2(N_IN + 1),
  parameter int N_STAGES  = 3,
  parameter int DEC_RATIO = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [N_IN-1:0]  in_bits,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W_OUT-1:0] out_count,
  output logic             dec_valid,
  output logic [W_OUT-1:0] dec_count
);
  localparam int N_LVL = popc_pkg::level_count(N_IN, W_OUT);
  localparam int LPS   = (N_LVL + N_STAGES - 1) / N_STAGES;
  localparam int CIW   = (W_OUT > 1) ? $clog2(W_OUT) : 1;
  localparam int KIW   = (N_IN  > 1) ? $clog2(N_IN)  : 1;

  typedef logic [W_OUT-1:0][N_IN-1:0] cols_t;

  logic  adv;
  cols_t first;
  cols_t fin;
  logic  spare;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_comb begin
    first    = '0;
    first[0] = in_bits;
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_st
    localparam int LO = (s * LPS < N_LVL) ? s * LPS : N_LVL;
    localparam int HI = ((s + 1) * LPS < N_LVL) ? (s + 1) * LPS : N_LVL;
    cols_t ib, ob;
    logic  iv, ov;
    if (s == 0) begin : g_head
      assign ib = first;
      assign iv = in_valid;
    end else begin : g_link
      assign ib = g_st[s-1].ob;
      assign iv = g_st[s-1].ov;
    end
    popc_stage #(.N_IN(N_IN), .W_OUT(W_OUT), .LVL_LO(LO), .LVL_HI(HI)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .i_valid (iv),
      .i_bits  (ib),
      .o_valid (ov),
      .o_bits  (ob)
    );
  end

  assign fin       = g_st[N_STAGES-1].ob;
  assign out_valid = g_st[N_STAGES-1].ov;

  always_comb begin
    spare = 1'b0;
    for (int c = 0; c < W_OUT; c++) begin
      out_count[CIW'(c)] = fin[CIW'(c)][0];
      for (int k = 1; k < N_IN; k++) spare = spare | fin[CIW'(c)][KIW'(k)];
    end
  end

  popc_decim #(.W_OUT(W_OUT), .RATIO(DEC_RATIO)) u_decim (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (out_valid && out_ready),
    .i_count (out_count),
    .o_valid (dec_valid),
    .o_count (dec_count)
  );

  // R1
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= W_OUT'(N_IN))
    else $error("count above input width");

  // R1
  spare_chk: assert property (@(posedge clk) disable iff (!rst_n) spare == 1'b0)
    else $error("tree did not reduce to one bit per column");

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_count))
    else $error("output changed while stalled");

endmodule

// File: tb/popc_decoder_tb.sv
module popc_decoder_tb;
  localparam int N     = 63;
  localparam int W     = 6;
  localparam int LAT   = 3;
  localparam int RATIO = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [N-1:0] in_bits = '0;
  logic         in_ready, out_valid, dec_valid;
  logic [W-1:0] out_count, dec_count;

  popc_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .dec_valid(dec_valid), .dec_count(dec_count)
  );

  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int fails  = 0;
  int q_cnt[$];
  int q_t[$];
  int scnt   = 0;
  int hs     = 0;
  bit exp_dv = 1'b0;
  int exp_dc = 0;
  bit lat_mode = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rnd();
    return N'({$urandom(), $urandom()});
  endfunction

  task automatic step(input bit v, input logic [N-1:0] b, input bit r);
    @(negedge clk);
    in_valid = v; in_bits = b; out_ready = r;
    #1;
    scnt++;
    // R8 / R7: readout pulse follows transfers 0, 32, 64, ... counted from reset
    chk(dec_valid == exp_dv, "R8 dec_valid", int'(dec_valid), int'(exp_dv));
    if (exp_dv) chk(int'(dec_count) == exp_dc, "R8 dec_count", int'(dec_count), exp_dc);
    exp_dv = 1'b0;
    chk(in_ready == (!out_valid || out_ready), "R5 in_ready", int'(in_ready),
        int'(!out_valid || out_ready));
    if (out_valid) begin
      if (q_cnt.size() == 0) chk(1'b0, "R4 spurious out_valid", 1, 0);
      else begin
        chk(int'(out_count) == q_cnt[0],
            (q_cnt[0] == 0 || q_cnt[0] == N) ? "R2 extreme count" : "R1 count (R6 order)",
            int'(out_count), q_cnt[0]);
        if (lat_mode) chk(scnt - q_t[0] == LAT, "R3 latency", scnt - q_t[0], LAT);
        if (out_ready) begin
          if (hs % RATIO == 0) begin exp_dv = 1'b1; exp_dc = q_cnt[0]; end
          hs++;
          void'(q_cnt.pop_front());
          void'(q_t.pop_front());
        end
      end
    end
    if (v && in_ready) begin
      q_cnt.push_back($countones(b));
      q_t.push_back(scnt);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R7 reset state
    chk(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    chk(dec_valid == 1'b0, "R7 dec_valid in reset", int'(dec_valid), 0);
    chk(out_count == '0,   "R7 out_count in reset", int'(out_count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    lat_mode = 1'b1;
    step(1'b1, '0, 1'b1);   // R2 zero
    step(1'b1, '1, 1'b1);   // R2 all ones
    step(1'b1, '0, 1'b1);
    for (int i = 0; i < N; i++) step(1'b1, N'(1) << i, 1'b1);    // R1 single bit anywhere
    for (int t = 0; t <= N; t++) begin                            // R1 bubbled thermometers
      logic [N-1:0] b;
      b = (t == N) ? '1 : ((N'(1) << t) - N'(1));
      b = b ^ (N'(1) << ($urandom % N)) ^ (N'(1) << ($urandom % N));
      step(1'b1, b, 1'b1);
    end
    for (int i = 0; i < 40; i++) step(i % 3 != 0, rnd(), 1'b1);  // R4 gaps, R3 timing
    for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b1);
    lat_mode = 1'b0;

    for (int i = 0; i < 900; i++)                                 // R5 R6 random stalls
      step($urandom % 4 != 0, rnd(), $urandom % 3 != 0);
    step(1'b1, '1, 1'b0);                                         // R5 long stall
    for (int i = 0; i < 6; i++) step(1'b1, rnd(), 1'b0);
    for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1);
    chk(q_cnt.size() == 0, "R6 results left behind", q_cnt.size(), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule